// File: doc/BRIEF.md
# Serial I/Q Sample Deserializer

This block collects a serial stream of 2-bit quantized I/Q samples from a radio front end and turns it into parallel words that a microcontroller reads from GPIO pins. Every front-end sample clock edge delivers one bit, and the bits repeat in a fixed order: I sign, I magnitude, Q sign, Q magnitude. The bits are shifted into a register. Rising edges of the front end's sync line decide when the register contents are copied to the parallel output.

The output works in one of two widths. Narrow mode gives a 4-bit word on every sync edge. Wide mode gives an 8-bit word on every second sync edge. Each new word toggles a phase line, so software that polls at an unknown rate can tell a fresh word from one it has already read. In wide mode a DMA request works as the stream's valid signal and the acknowledge input works as its ready signal. The front end cannot be stalled, so there is no back-pressure on it. If a new word completes while an earlier request has not yet been acknowledged, the new word replaces the old one and a sticky overrun flag records the loss.

The microcontroller drives a synchronous clear input. This clear returns the block to its idle state and is also the only time the width mode is read.

Top module: `sample_deser`

## Requirements
- R1: The front-end sample clock, data and sync inputs pass through a two-flop synchronizer. A bit is captured on each rising edge of the sample clock, and a sync event is a rising edge of the sync line. The effect of an edge is visible on the outputs by the third clock edge after the input changed.
- R2: In narrow mode (mode value 0), every sync event copies the last 4 captured bits into word_o[3:0], and word_o[7:4] reads 0.
- R3: phase_o toggles exactly once for each output word update, and word_o changes only on a clock edge where phase_o toggles. The only exception is a clear.
- R4: In wide mode (mode value 1), every second sync event after a clear copies the last 8 captured bits into word_o[7:0]. The first sync event after a clear leaves word_o and phase_o unchanged.
- R5: A clear sets the shifter, word_o, phase_o, the sync divider, dma_req_o and overrun_o to 0. A clear is either rst_n low (asynchronous) or mcu_clr_i high at a clock edge.
- R6: dma_req_o stays 0 in narrow mode. In wide mode it rises on the same edge as the word update.
- R7: Once raised, dma_req_o stays high until dma_ack_i is sampled high together with it. It then falls on that edge, unless a new word completes on the same edge.
- R8: overrun_o is set when a word completes while dma_req_o is high and dma_ack_i is low. It stays set until the next clear.
- R9: The first bit captured for a word appears in the word's most significant bit: bit 3 in narrow mode, bit 7 in wide mode. Later bits fill the lower positions in arrival order.
- R10: The mode is taken from wide_mode_i (1 = wide, 0 = narrow) only at edges where mcu_clr_i is high, and rst_n forces narrow mode. Changes on wide_mode_i at any other time have no effect.
- R11: If a sample clock edge and a sync event are detected on the same cycle, the bit captured on that cycle is part of the word latched by that sync event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| mcu_clr_i | input | 1 | Synchronous clear from the microcontroller; also samples the mode |
| wide_mode_i | input | 1 | Width select, 1 = 8-bit words, 0 = 4-bit words |
| fe_sclk_i | input | 1 | Front-end sample clock (asynchronous) |
| fe_sdat_i | input | 1 | Front-end serial sample bit (asynchronous) |
| fe_sync_i | input | 1 | Front-end sync pulse (asynchronous) |
| word_o | output | 8 | Parallel output word |
| phase_o | output | 1 | Toggles on every word update |
| dma_req_o | output | 1 | DMA request (valid) for wide words |
| dma_ack_i | input | 1 | DMA acknowledge (ready) |
| overrun_o | output | 1 | Sticky flag: a word completed before the previous one was acknowledged |

## Verification
The checker tests several rules on every clock cycle:
- the word changes only together with a phase toggle;
- no request is raised in narrow mode;
- a request holds until it is acknowledged and drops after acknowledge;
- the overrun flag is set when a word completes over a pending request, and then stays set;
- a clear leaves every output at zero;
- the latched mode does not change outside a clear.

Other behaviour can only be shown by the bench's stimulus scenarios:
- the assembled word values and their bit order;
- the divide-by-two of sync events in wide mode;
- the divider restarting after a clear in the middle of a word;
- the mode input being ignored outside a clear.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } deser_mode_e;
endpackage

// File: rtl/deser_sync.sv
// Multi-bit level synchronizer: STAGES flops per bit.
module deser_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/deser_shifter.sv
// Serial-in shifter; newest bit enters at bit 0 so the oldest sits highest.
module deser_shifter #(
  parameter int WIDE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WIDE_W-1:0] sh_next
);
  logic [WIDE_W-1:0] sh_q;

  always_comb begin
    sh_next = sh_q;
    if (shift_en) sh_next = {sh_q[WIDE_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh_q <= '0;
    else if (clr) sh_q <= '0;
    else          sh_q <= sh_next;
  end
endmodule

// File: rtl/deser_word_ctl.sv
// Sync divider, output word register and phase line.
module deser_word_ctl
  import deser_pkg::*;
#(
  parameter int NARROW_W = 4,
  parameter int WIDE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  deser_mode_e       mode,
  input  logic              sync_ev,
  input  logic [WIDE_W-1:0] sh_next,
  output logic [WIDE_W-1:0] word,
  output logic              phase,
  output logic              word_stb
);
  localparam int DIV = WIDE_W / NARROW_W;
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);

  logic [CW-1:0]     div_q;
  logic [WIDE_W-1:0] view;

  generate
    if (WIDE_W > NARROW_W) begin : g_pad
      assign view = (mode == MODE_WIDE) ? sh_next
                  : {{(WIDE_W-NARROW_W){1'b0}}, sh_next[NARROW_W-1:0]};
    end else begin : g_same
      assign view = sh_next;
    end
  endgenerate

  assign word_stb = sync_ev && ((mode == MODE_NARROW) || (div_q == DIV_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      word  <= '0;
      phase <= 1'b0;
    end else if (clr) begin
      div_q <= '0;
      word  <= '0;
      phase <= 1'b0;
    end else begin
      if (sync_ev && mode == MODE_WIDE)
        div_q <= (div_q == DIV_LAST) ? '0 : div_q + CW'(1);
      if (word_stb) begin
        word  <= view;
        phase <= ~phase;
      end
    end
  end
endmodule

// File: rtl/deser_dma.sv
// Request/acknowledge handshake with sticky overrun.
module deser_dma
  import deser_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  deser_mode_e mode,
  input  logic        word_stb,
  input  logic        ack,
  output logic        req,
  output logic        ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      ovr <= 1'b0;
    end else if (clr) begin
      req <= 1'b0;
      ovr <= 1'b0;
    end else if (mode == MODE_WIDE) begin
      if (word_stb) begin
        req <= 1'b1;
        if (req && !ack) ovr <= 1'b1;
      end else if (req && ack) begin
        req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sample_deser.sv
module sample_deser
  import deser_pkg::*;
#(
  parameter int NARROW_W    = 4,
  parameter int WIDE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mcu_clr_i,
  input  logic              wide_mode_i,
  input  logic              fe_sclk_i,
  input  logic              fe_sdat_i,
  input  logic              fe_sync_i,
  output logic [WIDE_W-1:0] word_o,
  output logic              phase_o,
  output logic              dma_req_o,
  input  logic              dma_ack_i,
  output logic              overrun_o
);
  deser_mode_e mode_q;
  logic [2:0]  fe_s;
  logic        sclk_d, sync_d;
  logic        shift_en, sync_ev, word_stb;
  logic [WIDE_W-1:0] sh_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= MODE_NARROW;
    else if (mcu_clr_i) mode_q <= wide_mode_i ? MODE_WIDE : MODE_NARROW;
  end

  deser_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({fe_sync_i, fe_sdat_i, fe_sclk_i}),
    .q(fe_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      sclk_d <= fe_s[0];
      sync_d <= fe_s[2];
    end
  end

  assign shift_en = fe_s[0] & ~sclk_d & ~mcu_clr_i;
  assign sync_ev  = fe_s[2] & ~sync_d & ~mcu_clr_i;

  deser_shifter #(.WIDE_W(WIDE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(mcu_clr_i),
    .shift_en(shift_en), .bit_in(fe_s[1]), .sh_next(sh_next)
  );

  deser_word_ctl #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_word (
    .clk(clk), .rst_n(rst_n), .clr(mcu_clr_i), .mode(mode_q),
    .sync_ev(sync_ev), .sh_next(sh_next),
    .word(word_o), .phase(phase_o), .word_stb(word_stb)
  );

  deser_dma u_dma (
    .clk(clk), .rst_n(rst_n), .clr(mcu_clr_i), .mode(mode_q),
    .word_stb(word_stb), .ack(dma_ack_i),
    .req(dma_req_o), .ovr(overrun_o)
  );
endmodule

// File: rtl/deser_checker.sv
module deser_checker #(
  parameter int WIDE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic [WIDE_W-1:0] word,
  input logic              phase,
  input logic              req,
  input logic              ack,
  input logic              ovr,
  input logic              wide,
  input logic              stb
);
  a_r3_word_with_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ((word != $past(word)) && !$past(clr)) |-> (phase != $past(phase)));

  a_r6_no_req_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> !req);

  a_r7_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && !clr) |=> req);

  a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !stb && !clr) |=> !req);

  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && req && !ack && !clr) |=> ovr);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr) |=> ovr);

  a_r5_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (word == '0) && !phase && !req && !ovr);

  a_r10_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(wide));
endmodule

bind sample_deser deser_checker #(.WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(mcu_clr_i),
  .word(word_o), .phase(phase_o), .req(dma_req_o), .ack(dma_ack_i),
  .ovr(overrun_o), .wide(mode_q == deser_pkg::MODE_WIDE), .stb(word_stb)
);

// File: tb/sample_deser_bench.sv
module sample_deser_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mcu_clr_i = 1'b0, wide_mode_i = 1'b0;
  logic fe_sclk_i = 1'b0, fe_sdat_i = 1'b0, fe_sync_i = 1'b0;
  logic dma_ack_i = 1'b0;
  logic [7:0] word_o;
  logic phase_o, dma_req_o, overrun_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_deser u_sample_deser (
    .clk(clk), .rst_n(rst_n), .mcu_clr_i(mcu_clr_i), .wide_mode_i(wide_mode_i),
    .fe_sclk_i(fe_sclk_i), .fe_sdat_i(fe_sdat_i), .fe_sync_i(fe_sync_i),
    .word_o(word_o), .phase_o(phase_o), .dma_req_o(dma_req_o),
    .dma_ack_i(dma_ack_i), .overrun_o(overrun_o)
  );

  // {mode, serial bits first-to-last, expected word}; narrow uses bits [7:4]
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'b1010_0000, 8'h0A},
    {1'b0, 8'b0111_0000, 8'h07},
    {1'b0, 8'b1000_0000, 8'h08},
    {1'b1, 8'b1011_0010, 8'hB2},
    {1'b1, 8'b0101_1100, 8'h5C},
    {1'b1, 8'b1111_1111, 8'hFF},
    {1'b1, 8'b0000_0001, 8'h01},
    {1'b0, 8'b1111_0000, 8'h0F}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    fe_sdat_i = b;
    wait_n(3);
    fe_sclk_i = 1'b1;
    wait_n(3);
    fe_sclk_i = 1'b0;
    wait_n(3);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int k = 0; k < n; k++) send_bit(v[7-k]);
  endtask

  task automatic pulse_sync();
    fe_sync_i = 1'b1;
    wait_n(3);
    fe_sync_i = 1'b0;
    wait_n(3);
  endtask

  task automatic do_clear(input logic wide);
    @(negedge clk);
    wide_mode_i = wide;
    mcu_clr_i = 1'b1;
    wait_n(2);
    mcu_clr_i = 1'b0;
    wait_n(1);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    dma_ack_i = 1'b1;
    @(negedge clk);
    dma_ack_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    // R5: state after chip reset
    chk("R5 reset word", word_o, 8'h00);
    chk("R5 reset phase", {7'b0, phase_o}, 8'h00);
    chk("R5 reset req", {7'b0, dma_req_o}, 8'h00);
    chk("R5 reset overrun", {7'b0, overrun_o}, 8'h00);

    // Table walk: R2, R4, R9 (bit order), R3 (one toggle per word)
    for (int i = 0; i < 8; i++) begin
      logic wide;
      logic [7:0] bits, exp;
      {wide, bits, exp} = VEC[i];
      do_clear(wide);
      if (!wide) begin
        send_bits(bits, 4);
        pulse_sync();
      end else begin
        send_bits(bits, 4);
        pulse_sync();
        chk("R4 first sync no update word", word_o, 8'h00);
        chk("R4 first sync no phase", {7'b0, phase_o}, 8'h00);
        send_bits({bits[3:0], 4'b0}, 4);
        pulse_sync();
      end
      chk("R2/R4/R9 word", word_o, exp);
      chk("R3 phase toggled", {7'b0, phase_o}, 8'h01);
    end

    // R3: bits without a sync leave the word alone; second word toggles back
    do_clear(1'b0);
    send_bits(8'b0110_0000, 4);
    pulse_sync();
    send_bits(8'b1001_0000, 4);
    chk("R3 stable without sync", word_o, 8'h06);
    chk("R3 phase unchanged", {7'b0, phase_o}, 8'h01);
    pulse_sync();
    chk("R3 second word", word_o, 8'h09);
    chk("R3 phase back to 0", {7'b0, phase_o}, 8'h00);
    chk("R6 no req narrow", {7'b0, dma_req_o}, 8'h00);

    // R10: mode input outside a clear has no effect (stays narrow)
    wide_mode_i = 1'b1;
    wait_n(3);
    send_bits(8'b1100_0000, 4);
    pulse_sync();
    chk("R10 still narrow word", word_o, 8'h0C);
    chk("R10 still narrow phase", {7'b0, phase_o}, 8'h01);
    wide_mode_i = 1'b0;

    // R6/R7: request hold and acknowledge
    do_clear(1'b1);
    send_bits(8'hA5, 8);
    chk("R6 no req before word", {7'b0, dma_req_o}, 8'h00);
    pulse_sync();
    pulse_sync();
    chk("R4 wide word after two syncs", word_o, 8'hA5);
    chk("R6 req raised", {7'b0, dma_req_o}, 8'h01);
    wait_n(10);
    chk("R7 req held", {7'b0, dma_req_o}, 8'h01);
    pulse_ack();
    chk("R7 req dropped", {7'b0, dma_req_o}, 8'h00);
    chk("R8 no overrun", {7'b0, overrun_o}, 8'h00);

    // R8: overrun sticky
    send_bits(8'h3C, 8);
    pulse_sync();
    pulse_sync();
    send_bits(8'hC3, 8);
    pulse_sync();
    pulse_sync();
    chk("R8 overrun set", {7'b0, overrun_o}, 8'h01);
    chk("R8 newest word kept", word_o, 8'hC3);
    pulse_ack();
    chk("R7 req dropped after overrun", {7'b0, dma_req_o}, 8'h00);
    chk("R8 overrun sticky", {7'b0, overrun_o}, 8'h01);
    do_clear(1'b1);
    chk("R5 clear overrun", {7'b0, overrun_o}, 8'h00);
    chk("R5 clear word", word_o, 8'h00);

    // R5: clear mid-word restarts the sync divider
    send_bits(8'hF0, 4);
    pulse_sync();
    do_clear(1'b1);
    send_bits(8'h96, 8);
    pulse_sync();
    chk("R5 divider restarted", {7'b0, phase_o}, 8'h00);
    pulse_sync();
    chk("R5 word after restart", word_o, 8'h96);

    // R11: sample edge and sync edge on the same cycle
    do_clear(1'b0);
    send_bits(8'b1010_0000, 3);
    fe_sdat_i = 1'b1;
    wait_n(3);
    fe_sclk_i = 1'b1;
    fe_sync_i = 1'b1;
    wait_n(3);
    fe_sclk_i = 1'b0;
    fe_sync_i = 1'b0;
    wait_n(3);
    chk("R11 coincident bit included", word_o, 8'h0B);
    chk("R1 phase after coincident edge", {7'b0, phase_o}, 8'h01);

    finish_run();
  end
endmodule